// File: doc/BRIEF.md
# Up/Down Tick Timer

An 8-bit counter that advances on a selectable timer tick. A 3-bit tick select picks among stopped, the system clock, four taps of a free-running prescaler, or the falling or rising edge of an external pin that is first synchronized into the clock domain. On each tick the operating mode decides whether the count goes up, goes down, bounces between its limits, or clears when it reaches compare channel A.

A host uses a small register bus to program the mode and tick select. It can read or overwrite the count at any time, and a write always wins over the tick operation in the same cycle. The host also loads two double-buffered compare values and clears the event flags. The three flags (wrap, compare A, compare B) drive the interrupt outputs directly. The top and bottom conditions of the count are also brought out as pins.

Top module: `updownTimer`

## Requirements
- R1: After reset the control register, count, compare buffers, active compare values and flags read 0, and the bounce direction is upward.
- R2: Register 0 bits [2:0] hold the tick select: 0 means no tick, and the count holds. 1 gives a tick on every cycle. 2, 3, 4 and 5 give one tick every 8, 64, 256 and 1024 cycles. Those ticks are taken from a 10-bit prescaler that counts every cycle from reset, on the cycles where its low 3, 6, 8 or 10 bits are all ones.
- R3: Select 6 ticks on a falling edge and select 7 on a rising edge of `extPin`. The pin passes two synchronizer flops and an edge-detect flop, so the count changes at the third rising clock edge after the pin changes.
- R4: Register 0 bits [4:3] hold the mode. In mode 0 each tick adds one and wraps from 0xFF to 0x00. In mode 1 each tick subtracts one and wraps from 0x00 to 0xFF. Only one of increment, decrement or clear acts per tick.
- R5: In mode 2 the count moves in its current direction. A tick at 0xFF while moving up steps to 0xFE and turns downward. A tick at 0x00 while moving down steps to 0x01 and turns upward. Any other mode forces the direction back to upward.
- R6: In mode 3 a tick clears the count to zero when it equals active compare A, and otherwise adds one.
- R7: `atTop` is high exactly while the count is 0xFF, and `atBottom` exactly while it is 0x00.
- R8: Register 1 reads the current count at any time. A host write to register 1 loads the count at that edge, in place of any tick operation.
- R9: Registers 2 and 3 are the compare buffers for channels A and B and read back what was written. Each active compare value copies its buffer on every cycle where the count is 0x00 or 0xFF. Registers 5 and 6 read the active values A and B, and register 7 reads 0.
- R10: Flag bit 1 (A) or bit 2 (B) of register 4 is set on a tick cycle where the count equals that channel's active compare value.
- R11: Flag bit 0 of register 4 is set on a tick that moves the count from 0xFF to 0x00 or from 0x00 to 0xFF.
- R12: Writing register 4 clears each flag whose data bit is 1, and a flag set in the same cycle stays set. No flag is set on a cycle where the host writes the count. `irqOvf`, `irqCmpA` and `irqCmpB` follow flag bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Register select |
| busWe | input | 1 | Write strobe for the selected register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the selected register, combinational |
| extPin | input | 1 | External tick pin, asynchronous |
| atTop | output | 1 | Count is at its maximum |
| atBottom | output | 1 | Count is zero |
| irqOvf | output | 1 | Wrap flag |
| irqCmpA | output | 1 | Compare A flag |
| irqCmpB | output | 1 | Compare B flag |

## Verification
The bench measures the number of increments over windows sized to each prescaler ratio. A design with a wrong tap would show the wrong difference. It writes the count while the timer runs, and the read that follows must be the written value plus one: a design that let the tick win would be off by one. It also writes the count in exactly the cycle a compare B match would fire. It checks that the B flag stays clear, which catches a design that leaks the match past the write. It drives the pin through both edge polarities to catch a swapped or unsynchronized edge. It loads a compare buffer while the count is away from the limits to show that the active value only follows at a limit. Bounce runs must pass both limits without ever raising the wrap flag.

// File: rtl/tmrPkg.sv
package tmrPkg;

  typedef struct packed {
    logic tick;
    logic inc;
    logic dec;
    logic clr;
  } tmrStrobe_t;

  typedef enum logic [1:0] {
    MODE_UP       = 2'd0,
    MODE_DOWN     = 2'd1,
    MODE_BOUNCE   = 2'd2,
    MODE_CLRMATCH = 2'd3
  } tmrMode_t;

  typedef enum logic [2:0] {
    ADDR_CTRL  = 3'd0,
    ADDR_CNT   = 3'd1,
    ADDR_BUFA  = 3'd2,
    ADDR_BUFB  = 3'd3,
    ADDR_FLAGS = 3'd4,
    ADDR_ACTA  = 3'd5,
    ADDR_ACTB  = 3'd6
  } tmrAddr_t;

  localparam int CTRL_W = 5;
  localparam int FLAG_W = 3;

endpackage

// File: rtl/tmrControl.sv
module tmrControl
  import tmrPkg::*;
#(
  parameter int TAP0_W = 3,
  parameter int TAP1_W = 6,
  parameter int TAP2_W = 8,
  parameter int TAP3_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              cntWrite,
  input  logic              extPin,
  input  logic              atTop,
  input  logic              atBottom,
  input  logic              matchA,
  output tmrStrobe_t        stb,
  output logic [CTRL_W-1:0] ctrlByte
);

  localparam int PRE_W    = TAP3_W;
  localparam int NUM_TAPS = 4;

  function automatic int tapWidth(input int idx);
    case (idx)
      0:       return TAP0_W;
      1:       return TAP1_W;
      2:       return TAP2_W;
      default: return TAP3_W;
    endcase
  endfunction

  logic [2:0]          csReg;
  tmrMode_t            modeReg;
  logic                dirUp, nextDirUp;
  logic [PRE_W-1:0]    preCnt;
  logic [1:0]          syncQ;
  logic                syncPrev;
  logic [NUM_TAPS-1:0] tapHit;
  logic                tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csReg   <= '0;
      modeReg <= MODE_UP;
    end else if (ctrlWrite) begin
      csReg   <= ctrlWdata[2:0];
      modeReg <= tmrMode_t'(ctrlWdata[4:3]);
    end
  end

  assign ctrlByte = {modeReg, csReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      syncQ    <= '0;
      syncPrev <= 1'b0;
    end else begin
      preCnt   <= preCnt + 1'b1;
      syncQ    <= {syncQ[0], extPin};
      syncPrev <= syncQ[1];
    end
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    localparam int W = tapWidth(g);
    assign tapHit[g] = &preCnt[W-1:0];
  end

  always_comb begin
    case (csReg)
      3'd0:    tick = 1'b0;
      3'd1:    tick = 1'b1;
      3'd2:    tick = tapHit[0];
      3'd3:    tick = tapHit[1];
      3'd4:    tick = tapHit[2];
      3'd5:    tick = tapHit[3];
      3'd6:    tick = syncPrev & ~syncQ[1];
      default: tick = ~syncPrev & syncQ[1];
    endcase
  end

  always_comb begin
    stb       = '0;
    stb.tick  = tick;
    nextDirUp = dirUp;
    if (tick) begin
      case (modeReg)
        MODE_UP:   stb.inc = 1'b1;
        MODE_DOWN: stb.dec = 1'b1;
        MODE_BOUNCE: begin
          if (dirUp) begin
            if (atTop) begin
              stb.dec   = 1'b1;
              nextDirUp = 1'b0;
            end else begin
              stb.inc = 1'b1;
            end
          end else begin
            if (atBottom) begin
              stb.inc   = 1'b1;
              nextDirUp = 1'b1;
            end else begin
              stb.dec = 1'b1;
            end
          end
        end
        default: begin
          if (matchA) stb.clr = 1'b1;
          else        stb.inc = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     dirUp <= 1'b1;
    else if (modeReg != MODE_BOUNCE) dirUp <= 1'b1;
    else if (tick && !cntWrite)    dirUp <= nextDirUp;
  end

  AST_BOUNCE_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_BOUNCE && stb.tick && dirUp && atTop) |-> stb.dec); // R5

  AST_DIR_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_BOUNCE && stb.tick && dirUp && atTop && !cntWrite && !ctrlWrite)
      |=> !dirUp); // R5

  AST_CLR_ONLY_AT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |-> (matchA && modeReg == MODE_CLRMATCH)); // R6

endmodule

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import tmrPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tmrStrobe_t                 stb,
  input  logic                       cntWrite,
  input  logic [1:0]                 bufWrite,
  input  logic                       flagWrite,
  input  logic [CNT_W-1:0]           wdata,
  output logic [CNT_W-1:0]           cnt,
  output logic [1:0][CNT_W-1:0]      bufVal,
  output logic [1:0][CNT_W-1:0]      actVal,
  output logic [FLAG_W-1:0]          flags,
  output logic                       atTop,
  output logic                       atBottom,
  output logic                       matchA
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int NUM_CMP = 2;

  logic [CNT_W-1:0]   stepCnt;
  logic               tickLive, wrapEv;
  logic [NUM_CMP-1:0] match, hit;
  logic [CNT_W-1:0]   bufMem [NUM_CMP];
  logic [CNT_W-1:0]   actMem [NUM_CMP];
  logic [FLAG_W-1:0]  clrBits, setBits;

  assign atTop    = (cnt == CNT_MAX);
  assign atBottom = (cnt == '0);
  assign tickLive = stb.tick & ~cntWrite;

  always_comb begin
    stepCnt = cnt;
    if (stb.clr)      stepCnt = '0;
    else if (stb.inc) stepCnt = cnt + 1'b1;
    else if (stb.dec) stepCnt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (cntWrite) cnt <= wdata;
    else               cnt <= stepCnt;
  end

  assign wrapEv = tickLive & ((atTop && stepCnt == '0) || (atBottom && stepCnt == CNT_MAX));

  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufMem[g] <= '0;
        actMem[g] <= '0;
      end else begin
        if (bufWrite[g])        bufMem[g] <= wdata;
        if (atTop || atBottom)  actMem[g] <= bufMem[g];
      end
    end
    assign bufVal[g] = bufMem[g];
    assign actVal[g] = actMem[g];
    assign match[g]  = (cnt == actMem[g]);
    assign hit[g]    = tickLive & match[g];
  end

  assign matchA  = match[0];
  assign setBits = {hit[1], hit[0], wrapEv};
  assign clrBits = flagWrite ? wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrBits) | setBits;
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> (cnt == $past(wdata))); // R8

  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.inc, stb.dec, stb.clr})); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tick && !cntWrite) |=> $stable(cnt)); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clr && !cntWrite) |=> (cnt == '0)); // R6

  AST_MATCH_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrite && !flagWrite) |=> (flags == $past(flags))); // R12

endmodule

// File: rtl/updownTimer.sv
module updownTimer
  import tmrPkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TAP0_W = 3,
  parameter int TAP1_W = 6,
  parameter int TAP2_W = 8,
  parameter int TAP3_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       busAddr,
  input  logic             busWe,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  input  logic             extPin,
  output logic             atTop,
  output logic             atBottom,
  output logic             irqOvf,
  output logic             irqCmpA,
  output logic             irqCmpB
);

  tmrStrobe_t              stb;
  logic [CTRL_W-1:0]       ctrlByte;
  logic [CNT_W-1:0]        cnt;
  logic [1:0][CNT_W-1:0]   bufVal, actVal;
  logic [FLAG_W-1:0]       flags;
  logic                    matchA;
  logic                    ctrlWrite, cntWrite, flagWrite;
  logic [1:0]              bufWrite;

  assign ctrlWrite   = busWe && (busAddr == ADDR_CTRL);
  assign cntWrite    = busWe && (busAddr == ADDR_CNT);
  assign bufWrite[0] = busWe && (busAddr == ADDR_BUFA);
  assign bufWrite[1] = busWe && (busAddr == ADDR_BUFB);
  assign flagWrite   = busWe && (busAddr == ADDR_FLAGS);

  tmrControl #(
    .TAP0_W(TAP0_W), .TAP1_W(TAP1_W), .TAP2_W(TAP2_W), .TAP3_W(TAP3_W)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .ctrlWrite(ctrlWrite), .ctrlWdata(busWdata[CTRL_W-1:0]),
    .cntWrite(cntWrite), .extPin(extPin),
    .atTop(atTop), .atBottom(atBottom), .matchA(matchA),
    .stb(stb), .ctrlByte(ctrlByte)
  );

  tmrDatapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cntWrite(cntWrite), .bufWrite(bufWrite), .flagWrite(flagWrite),
    .wdata(busWdata), .cnt(cnt), .bufVal(bufVal), .actVal(actVal),
    .flags(flags), .atTop(atTop), .atBottom(atBottom), .matchA(matchA)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL:  busRdata = {{(CNT_W-CTRL_W){1'b0}}, ctrlByte};
      ADDR_CNT:   busRdata = cnt;
      ADDR_BUFA:  busRdata = bufVal[0];
      ADDR_BUFB:  busRdata = bufVal[1];
      ADDR_FLAGS: busRdata = {{(CNT_W-FLAG_W){1'b0}}, flags};
      ADDR_ACTA:  busRdata = actVal[0];
      ADDR_ACTB:  busRdata = actVal[1];
      default:    busRdata = '0;
    endcase
  end

  assign irqOvf  = flags[0];
  assign irqCmpA = flags[1];
  assign irqCmpB = flags[2];

endmodule

// File: tb/updownTimer_bench.sv
`timescale 1ns/100ps
module updownTimer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       extPin = 1'b0;
  logic       atTop, atBottom, irqOvf, irqCmpA, irqCmpB;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #2 clk = ~clk;

  updownTimer u_updownTimer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .extPin(extPin),
    .atTop(atTop), .atBottom(atBottom), .irqOvf(irqOvf),
    .irqCmpA(irqCmpA), .irqCmpB(irqCmpB)
  );

  // behavioural reference model
  int mCnt, mPre, mCs, mMode, mDirUp, mS0, mS1, mPrev, mFlags;
  int mBuf [2];
  int mAct [2];

  always @(posedge clk) begin
    int tk, nc, nd, cw, liveT, newFlags, a;
    if (!rstN) begin
      mCnt = 0; mPre = 0; mCs = 0; mMode = 0; mDirUp = 1;
      mS0 = 0; mS1 = 0; mPrev = 0; mFlags = 0;
      mBuf[0] = 0; mBuf[1] = 0; mAct[0] = 0; mAct[1] = 0;
    end else begin
      a = busAddr;
      case (mCs)
        0: tk = 0;
        1: tk = 1;
        2: tk = (mPre % 8 == 7);
        3: tk = (mPre % 64 == 63);
        4: tk = (mPre % 256 == 255);
        5: tk = (mPre == 1023);
        6: tk = (mPrev == 1 && mS1 == 0);
        default: tk = (mPrev == 0 && mS1 == 1);
      endcase
      cw = busWe && a == 1;
      nc = mCnt; nd = mDirUp;
      if (tk) begin
        case (mMode)
          0: nc = (mCnt + 1) % 256;
          1: nc = (mCnt + 255) % 256;
          2: begin
            if (mDirUp) begin
              if (mCnt == 255) begin nc = 254; nd = 0; end else nc = mCnt + 1;
            end else begin
              if (mCnt == 0) begin nc = 1; nd = 1; end else nc = mCnt - 1;
            end
          end
          default: nc = (mCnt == mAct[0]) ? 0 : (mCnt + 1) % 256;
        endcase
      end
      liveT = tk && !cw;
      newFlags = mFlags;
      if (busWe && a == 4) newFlags = newFlags & ~(busWdata & 7);
      if (liveT && ((mCnt == 255 && nc == 0) || (mCnt == 0 && nc == 255))) newFlags |= 1;
      if (liveT && mCnt == mAct[0]) newFlags |= 2;
      if (liveT && mCnt == mAct[1]) newFlags |= 4;
      mFlags = newFlags;
      if (mCnt == 0 || mCnt == 255) begin mAct[0] = mBuf[0]; mAct[1] = mBuf[1]; end
      if (busWe && a == 2) mBuf[0] = busWdata;
      if (busWe && a == 3) mBuf[1] = busWdata;
      if (mMode != 2) mDirUp = 1;
      else if (liveT) mDirUp = nd;
      mCnt = cw ? int'(busWdata) : nc;
      if (busWe && a == 0) begin mCs = busWdata & 7; mMode = (busWdata >> 3) & 3; end
      mPrev = mS1; mS1 = mS0; mS0 = extPin;
      mPre = (mPre + 1) % 1024;
    end
  end

  function automatic int expRead(input int a);
    case (a)
      0: return (mMode << 3) | mCs;
      1: return mCnt;
      2: return mBuf[0];
      3: return mBuf[1];
      4: return mFlags;
      5: return mAct[0];
      6: return mAct[1];
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int got, want;
    if (rstN && !done) begin
      got  = {busRdata, atTop, atBottom, irqOvf, irqCmpA, irqCmpB};
      want = (expRead(busAddr) << 5) | ((mCnt == 255) << 4) | ((mCnt == 0) << 3)
           | ((mFlags & 1) << 2) | (((mFlags >> 1) & 1) << 1) | ((mFlags >> 2) & 1);
      check(got == want, {curReq, " model"}, got, want);
    end
  end

  task automatic busWrite(input int a, input int d);
    @(negedge clk); #0.5;
    busAddr = a[2:0]; busWe = 1'b1; busWdata = d[7:0];
    @(negedge clk); #0.5;
    busWe = 1'b0;
  endtask

  task automatic readCheck(input int a, input int exp, input string tag);
    @(negedge clk); #0.5;
    busAddr = a[2:0];
    #0.5;
    check(busRdata == exp[7:0], tag, busRdata, exp);
  endtask

  task automatic readCnt(output int v);
    @(negedge clk); #0.5;
    busAddr = 3'd1;
    #0.5;
    v = busRdata;
  endtask

  task automatic setPin(input bit v);
    @(negedge clk); #0.5;
    extPin = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, c1, tops, bottoms;
    idle(5); #0.5; rstN = 1'b1;

    curReq = "R1";
    readCheck(0, 0, "R1");
    readCheck(1, 0, "R1");
    readCheck(4, 0, "R1");
    readCheck(5, 0, "R1");
    readCheck(7, 0, "R9");

    curReq = "R2";
    busWrite(1, 'h42);
    idle(40);
    readCheck(1, 'h42, "R2 stopped count holds");

    curReq = "R8";
    busWrite(0, 'h01);
    busWrite(1, 'h80);
    readCheck(1, 'h81, "R8 write wins over tick");

    curReq = "R2";
    busWrite(0, 2); readCnt(c0); idle(1023); readCnt(c1);
    check(((c1 - c0) & 255) == 128, "R2 divide 8", (c1 - c0) & 255, 128);
    busWrite(0, 3); readCnt(c0); idle(2047); readCnt(c1);
    check(((c1 - c0) & 255) == 32, "R2 divide 64", (c1 - c0) & 255, 32);
    busWrite(0, 4); readCnt(c0); idle(4095); readCnt(c1);
    check(((c1 - c0) & 255) == 16, "R2 divide 256", (c1 - c0) & 255, 16);
    busWrite(0, 5); readCnt(c0); idle(4095); readCnt(c1);
    check(((c1 - c0) & 255) == 4, "R2 divide 1024", (c1 - c0) & 255, 4);

    curReq = "R3";
    busWrite(0, 0); busWrite(4, 7); busWrite(1, 0);
    busWrite(0, 6);
    setPin(1); idle(6); readCheck(1, 0, "R3 rising ignored on falling select");
    setPin(0); idle(6); readCheck(1, 1, "R3 falling edge tick");
    setPin(1); idle(6); readCheck(1, 1, "R3 rising ignored");
    busWrite(0, 7);
    setPin(0); idle(6); readCheck(1, 1, "R3 falling ignored on rising select");
    setPin(1); idle(6); readCheck(1, 2, "R3 rising edge tick");

    curReq = "R11";
    busWrite(0, 0); busWrite(4, 7); busWrite(1, 2);
    busWrite(0, 'h09);
    idle(8);
    check(irqOvf == 1'b1, "R11 down wrap sets flag", irqOvf, 1);
    curReq = "R12";
    busWrite(0, 0); busWrite(4, 7);
    readCheck(4, 0, "R12 write one clears flags");

    curReq = "R9";
    busWrite(1, 'h30); busWrite(2, 5); busWrite(3, 'h20);
    readCheck(2, 5, "R9 buffer A readback");
    readCheck(5, 0, "R9 active A waits for limit");
    busWrite(1, 0); idle(2);
    readCheck(5, 5, "R9 active A loaded at bottom");
    readCheck(6, 'h20, "R9 active B loaded at bottom");

    curReq = "R6";
    busWrite(4, 7); busWrite(0, 'h19);
    idle(40);
    check(irqCmpA == 1'b1, "R6 match A flag in clear mode", irqCmpA, 1);
    busWrite(0, 'h18);
    readCnt(c0);
    check(c0 <= 5, "R6 count stays within compare A", c0, 5);

    curReq = "R12";
    busWrite(0, 0); busWrite(4, 7);
    busWrite(0, 'h01);
    busWrite(1, 'h1F);
    busWrite(1, 'h50);
    busWrite(0, 0);
    check(irqCmpB == 1'b0, "R12 match blocked by count write", irqCmpB, 0);

    curReq = "R10";
    busWrite(1, 'h1C); busWrite(0, 'h01);
    idle(6);
    busWrite(0, 0);
    check(irqCmpB == 1'b1, "R10 match B sets flag", irqCmpB, 1);

    curReq = "R5";
    busWrite(4, 7); busWrite(1, 'hF0); busWrite(0, 'h11);
    tops = 0; bottoms = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      if (atTop) tops++;
      if (atBottom) bottoms++;
    end
    busWrite(0, 0);
    check(irqOvf == 1'b0, "R5 bounce never wraps", irqOvf, 0);
    check(tops == 2, "R7 top seen on each upper turn", tops, 2);
    check(bottoms == 1, "R7 bottom seen once", bottoms, 1);

    curReq = "R4";
    busWrite(4, 7); busWrite(1, 'hFE); busWrite(0, 'h01);
    idle(4);
    busWrite(0, 0);
    check(irqOvf == 1'b1, "R4 up wrap", irqOvf, 1);

    idle(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule